// File: doc/BRIEF.md
# Page Permission Remap Unit

This block turns the access-permission and execute-never bits of a page-table entry into effective read, write and execute grants. It does not decode those bits directly. The four bits form an index into a programmable 64-bit permission register that holds sixteen 4-bit entries. Each entry carries one 2-bit field for normal mode and one 2-bit field for guarded mode. The current privilege level (EL0 or EL1) picks one of two permission registers, and a mode flag picks the field.

The lookup is purely combinational. A configuration register turns remapping on or off and holds three set-only lock bits. While remapping is off, a fixed, conventional decode of the AP and XN bits supplies the grants. The configuration register and both permission registers are loaded through one register-write port.

Top module: `perm_remap_unit`

## Requirements
- R1: The lookup index is {ap[1], ap[0], uxn, pxn}, with pxn in bit 0. The selected entry occupies bits [4*index+3 : 4*index] of the active permission register.
- R2: In guarded mode (guarded=1), with remapping on, entry bits [3:2] decode as follows: 00 gives no access, 01 gives read+execute, 10 gives read-only and 11 gives read+write.
- R3: In normal mode (guarded=0), with remapping on, entry bits [1:0] decode with the same encoding as in R2, apart from the cases in R4 and R5.
- R4: An entry whose guarded field is 01 and whose normal field is 11 gives no access in normal mode.
- R5: An entry whose guarded field is 10 and whose normal field is 01 gives execute-only access in normal mode.
- R6: With priv_el1=0 the EL0 permission register is used; with priv_el1=1 the EL1 permission register is used.
- R7: On a clock edge with wr_en=1, wr_sel selects the target register: 0 loads the configuration, 1 loads the EL0 permission register and 2 loads the EL1 permission register. wr_sel=3 changes nothing. The new value steers the grants from the following cycle onward.
- R8: In the configuration register, bit 0 enables remapping. Bits 1, 4 and 5 lock the configuration, the EL0 permission register and the EL1 permission register respectively. A write can set a lock bit but never clear it; only reset clears it.
- R9: While the configuration lock is set, a configuration write changes neither the enable bit nor any lock bit.
- R10: A write to a permission register whose lock bit is set leaves that register unchanged.
- R11: With remapping off, the guarded flag has no effect. In that state the grants are:
  - read = priv_el1 | ap[0]
  - write = !ap[1] & (priv_el1 | ap[0])
  - execute = priv_el1 ? !pxn : (!uxn & ap[0])
- R12: A synchronous active-low reset clears the enable bit, all lock bits and both permission registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 config, 1 EL0 permissions, 2 EL1 permissions |
| wr_data | input | 64 | Write data |
| ap | input | 2 | Page access-permission bits |
| uxn | input | 1 | Unprivileged execute-never bit |
| pxn | input | 1 | Privileged execute-never bit |
| priv_el1 | input | 1 | 1 when the access is made at EL1 |
| guarded | input | 1 | 1 when the core runs in guarded mode |
| grant_r | output | 1 | Read granted |
| grant_w | output | 1 | Write granted |
| grant_x | output | 1 | Execute granted |

## Verification
The assertions assume that reset is held for at least one edge before any write. They also assume that lookup inputs change only between edges, so that the combinational grant checks always see a settled entry. The bench meets both assumptions by driving every input on the falling edge.

Random configuration writes set a lock bit only rarely, so most of the run exercises unlocked registers. Directed sequences then cover the locked states and the two normal-mode override entries. A second reset in the middle of the run clears the locks and lets random writes resume.

// File: rtl/perm_remap_pkg.sv
// Shared constants and types for the page permission remap unit.
// Assumes one 4-bit entry per page-permission combination and two
// privilege-indexed permission registers.
package perm_remap_pkg;

    localparam int IDX_W      = 4;
    localparam int ENTRY_W    = 4;
    localparam int N_ENTRIES  = 1 << IDX_W;
    localparam int PERM_W     = N_ENTRIES * ENTRY_W;
    localparam int N_PRIV     = 2;
    localparam int SEL_W      = 2;

    // Configuration bit positions (decoded by software, so they are fixed)
    localparam int CFG_EN_BIT      = 0;
    localparam int CFG_LOCK_CFG    = 1;
    localparam int CFG_LOCK_PERM0  = 4;
    localparam int CFG_LOCK_PERM1  = 5;

    // Write target codes
    localparam logic [SEL_W-1:0] SEL_CFG   = 2'd0;
    localparam logic [SEL_W-1:0] SEL_PERM0 = 2'd1;
    localparam logic [SEL_W-1:0] SEL_PERM1 = 2'd2;

    // 2-bit field encoding
    typedef enum logic [1:0] {
        FLD_NONE = 2'b00,
        FLD_RX   = 2'b01,
        FLD_RO   = 2'b10,
        FLD_RW   = 2'b11
    } field_e;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } grant_t;

    // Plain decode of one field
    function automatic grant_t field_to_grant(input logic [1:0] f);
        grant_t g;
        case (field_e'(f))
            FLD_RX:  g = '{r: 1'b1, w: 1'b0, x: 1'b1};
            FLD_RO:  g = '{r: 1'b1, w: 1'b0, x: 1'b0};
            FLD_RW:  g = '{r: 1'b1, w: 1'b1, x: 1'b0};
            default: g = '{r: 1'b0, w: 1'b0, x: 1'b0};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/remap_cfg_reg.sv
// Configuration register: remap enable plus three set-only lock bits.
// Assumes the caller qualifies wr_en with the configuration target code.
// When the configuration lock is set, writes are dropped entirely.
module remap_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic in_en,
    input  logic in_lock_cfg,
    input  logic in_lock_p0,
    input  logic in_lock_p1,
    output logic en,
    output logic lock_cfg,
    output logic lock_p0,
    output logic lock_p1
);

    // Load enable and accumulate lock bits unless the configuration is frozen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            lock_cfg <= 1'b0;
            lock_p0  <= 1'b0;
            lock_p1  <= 1'b0;
        end else if (wr_en && !lock_cfg) begin
            en       <= in_en;
            lock_cfg <= in_lock_cfg;
            lock_p0  <= lock_p0 | in_lock_p0;
            lock_p1  <= lock_p1 | in_lock_p1;
        end
    end

    // R8: lock bits never fall outside reset
    a_r8_lock_cfg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_cfg) |-> lock_cfg);
    a_r8_lock_p0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_p0) |-> lock_p0);
    a_r8_lock_p1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_p1) |-> lock_p1);

    // R9: a frozen configuration keeps its enable bit
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_cfg) |-> $stable(en));

endmodule

// File: rtl/remap_perm_reg.sv
// One lockable permission register holding all lookup entries.
// Assumes the lock input comes from a register, so it is stable
// around the clock edge.
module remap_perm_reg #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             lock,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] perm
);

    // Load the whole register unless it is locked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            perm <= '0;
        end else if (wr_en && !lock) begin
            perm <= wr_data;
        end
    end

    // R10: a locked register holds its contents
    a_r10_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock) |-> $stable(perm));

endmodule

// File: rtl/remap_entry_decode.sv
// Decodes one 4-bit entry into grants for the current mode.
// Assumes the entry layout {guarded[1:0], normal[1:0]}. Two guarded
// values reinterpret specific normal values.
module remap_entry_decode
    import perm_remap_pkg::*;
(
    input  logic [ENTRY_W-1:0] entry,
    input  logic               guarded,
    output grant_t             grant
);

    logic [1:0] nrm_f;
    logic [1:0] grd_f;
    grant_t     nrm_g;
    grant_t     grd_g;

    assign nrm_f = entry[1:0];
    assign grd_f = entry[3:2];

    // Normal-mode field with the two guarded-dependent overrides
    always_comb begin
        nrm_g = field_to_grant(nrm_f);
        if (grd_f == FLD_RX && nrm_f == FLD_RW) begin
            nrm_g = '{r: 1'b0, w: 1'b0, x: 1'b0};
        end else if (grd_f == FLD_RO && nrm_f == FLD_RX) begin
            nrm_g = '{r: 1'b0, w: 1'b0, x: 1'b1};
        end
    end

    // Guarded-mode field decodes plainly
    always_comb grd_g = field_to_grant(grd_f);

    // Select by mode
    always_comb grant = guarded ? grd_g : nrm_g;

    // R2/R3: remapped pages are never both writable and executable,
    // and writable implies readable
    always_comb begin
        a_r3_no_wx: assert (!(grant.w && grant.x));
        a_r2_w_implies_r: assert (!grant.w || grant.r);
    end

endmodule

// File: rtl/remap_fixed_decode.sv
// Conventional AP/XN decode used while remapping is disabled.
// Assumes ap[0] grants EL0 access and ap[1] marks the page read-only.
module remap_fixed_decode
    import perm_remap_pkg::*;
(
    input  logic [1:0] ap,
    input  logic       uxn,
    input  logic       pxn,
    input  logic       priv_el1,
    output grant_t     grant
);

    logic reach;

    // Privilege may touch the page at all
    always_comb reach = priv_el1 | ap[0];

    // Fixed rights
    always_comb begin
        grant.r = reach;
        grant.w = reach & ~ap[1];
        grant.x = priv_el1 ? ~pxn : (~uxn & ap[0]);
    end

    // R11: writable implies readable in the fixed decode as well
    always_comb a_r11_fixed_w_implies_r: assert (!grant.w || grant.r);

endmodule

// File: rtl/perm_remap_unit.sv
// Page permission remap unit top. Holds the configuration and two
// privilege-indexed permission registers. Grants are combinational
// from the page bits and the current register state.
// Assumes a write becomes visible from the cycle after its edge.
module perm_remap_unit
    import perm_remap_pkg::*;
#(
    parameter int DATA_W = PERM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        ap,
    input  logic              uxn,
    input  logic              pxn,
    input  logic              priv_el1,
    input  logic              guarded,
    output logic              grant_r,
    output logic              grant_w,
    output logic              grant_x
);

    logic              cfg_en;
    logic              cfg_lock;
    logic              lock_p0;
    logic              lock_p1;
    logic [N_PRIV-1:0] perm_lock;
    logic [PERM_W-1:0] perm_q [N_PRIV];
    logic [PERM_W-1:0] act_perm;
    logic [IDX_W-1:0]  idx;
    logic [ENTRY_W-1:0] entry_arr [N_ENTRIES];
    logic [ENTRY_W-1:0] entry;
    grant_t            remap_g;
    grant_t            fixed_g;
    grant_t            out_g;

    remap_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en && (wr_sel == SEL_CFG)),
        .in_en      (wr_data[CFG_EN_BIT]),
        .in_lock_cfg(wr_data[CFG_LOCK_CFG]),
        .in_lock_p0 (wr_data[CFG_LOCK_PERM0]),
        .in_lock_p1 (wr_data[CFG_LOCK_PERM1]),
        .en         (cfg_en),
        .lock_cfg   (cfg_lock),
        .lock_p0    (lock_p0),
        .lock_p1    (lock_p1)
    );

    assign perm_lock = {lock_p1, lock_p0};

    // One permission register per privilege level
    for (genvar p = 0; p < N_PRIV; p++) begin : g_perm
        remap_perm_reg #(.WIDTH(PERM_W)) u_perm (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en && (wr_sel == SEL_W'(p + 1))),
            .lock   (perm_lock[p]),
            .wr_data(wr_data[PERM_W-1:0]),
            .perm   (perm_q[p])
        );
    end

    // Privilege picks the active register
    always_comb act_perm = priv_el1 ? perm_q[1] : perm_q[0];

    // Split the active register into entries
    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_split
        assign entry_arr[e] = act_perm[e*ENTRY_W +: ENTRY_W];
    end

    // Form the index and pick the entry
    always_comb begin
        idx   = {ap[1], ap[0], uxn, pxn};
        entry = entry_arr[idx];
    end

    remap_entry_decode u_ent (
        .entry  (entry),
        .guarded(guarded),
        .grant  (remap_g)
    );

    remap_fixed_decode u_fix (
        .ap      (ap),
        .uxn     (uxn),
        .pxn     (pxn),
        .priv_el1(priv_el1),
        .grant   (fixed_g)
    );

    // Enable selects remapped or fixed rights
    always_comb out_g = cfg_en ? remap_g : fixed_g;

    assign grant_r = out_g.r;
    assign grant_w = out_g.w;
    assign grant_x = out_g.x;

    // R6: with remapping on, a zero active register grants nothing
    always_comb
        if (rst_n && cfg_en && act_perm == '0)
            a_r6_zero_reg_no_access: assert (!grant_r && !grant_w && !grant_x);

    // R10: an EL1 register write while locked leaves the lookup source unchanged
    a_r10_el1_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_p1) && $past(wr_en) && $past(wr_sel) == SEL_PERM1) |-> $stable(perm_q[1]));

endmodule

// File: tb/test_perm_remap_unit.sv
module test_perm_remap_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [63:0] wr_data = '0;
    logic [1:0]  ap = 2'd0;
    logic        uxn = 1'b0, pxn = 1'b0, priv_el1 = 1'b0, guarded = 1'b0;
    logic        grant_r, grant_w, grant_x;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // shadow model
    bit m_en, m_lc, m_l0, m_l1;
    logic [63:0] m_p0, m_p1;

    perm_remap_unit i_perm_remap_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ap(ap), .uxn(uxn), .pxn(pxn), .priv_el1(priv_el1), .guarded(guarded),
        .grant_r(grant_r), .grant_w(grant_w), .grant_x(grant_x)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2:0] fld(input logic [1:0] f);
        case (f)
            2'b01: return 3'b101;
            2'b10: return 3'b100;
            2'b11: return 3'b110;
            default: return 3'b000;
        endcase
    endfunction

    // expected {r,w,x}
    function automatic logic [2:0] expect_g(input logic [1:0] a, input logic u, input logic p,
                                            input logic e1, input logic g);
        logic [3:0] ix, ent;
        logic [63:0] reg_v;
        logic rd;
        if (!m_en) begin
            rd = e1 | a[0];
            return {rd, rd & ~a[1], e1 ? ~p : (~u & a[0])};
        end
        ix = {a, u, p};
        reg_v = e1 ? m_p1 : m_p0;
        ent = reg_v[ix*4 +: 4];
        if (g) return fld(ent[3:2]);
        if (ent == 4'b0111) return 3'b000;
        if (ent == 4'b1001) return 3'b001;
        return fld(ent[1:0]);
    endfunction

    task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp_v);
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got rwx=%b expected rwx=%b (ap=%b uxn=%b pxn=%b el1=%b g=%b)",
                     req, got, exp_v, ap, uxn, pxn, priv_el1, guarded);
        end
    endtask

    task automatic look(input logic [1:0] a, input logic u, input logic p,
                        input logic e1, input logic g, input string req);
        ap = a; uxn = u; pxn = p; priv_el1 = e1; guarded = g;
        #1;
        chk(req, {grant_r, grant_w, grant_x}, expect_g(a, u, p, e1, g));
    endtask

    task automatic do_write(input logic [1:0] s, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (s)
            2'd0: if (!m_lc) begin
                m_en = d[0]; m_lc = d[1]; m_l0 |= d[4]; m_l1 |= d[5];
            end
            2'd1: if (!m_l0) m_p0 = d;
            2'd2: if (!m_l1) m_p1 = d;
            default: ;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        m_en = 0; m_lc = 0; m_l0 = 0; m_l1 = 0; m_p0 = '0; m_p1 = '0;
    endtask

    // all 16 indices in both modes, one privilege
    task automatic sweep(input logic e1, input string req);
        for (int i = 0; i < 16; i++) begin
            look(i[3:2], i[1], i[0], e1, 1'b0, req);
            look(i[3:2], i[1], i[0], e1, 1'b1, req);
        end
    endtask

    task automatic random_phase(input int n, input bit allow_lock);
        logic [63:0] d;
        logic [1:0] s;
        for (int k = 0; k < n; k++) begin
            if ($urandom_range(0, 2) == 0) begin
                s = 2'($urandom_range(0, 3));
                d = {$urandom, $urandom};
                if (s == 2'd0) begin
                    d[1] = 1'b0; d[4] = 1'b0; d[5] = 1'b0;
                    if (allow_lock && $urandom_range(0, 30) == 0) d[4] = 1'b1;
                    if (allow_lock && $urandom_range(0, 30) == 0) d[5] = 1'b1;
                    if (allow_lock && $urandom_range(0, 60) == 0) d[1] = 1'b1;
                end
                do_write(s, d);
            end
            look(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 "R1/R2/R3/R6/R7 random");
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R12: reset leaves remap off -> fixed decode
        sweep(1'b0, "R12 reset fixed EL0");
        sweep(1'b1, "R12 reset fixed EL1");
        // R11: guarded ignored while off
        look(2'b01, 1'b0, 1'b1, 1'b0, 1'b1, "R11 guard ignored");
        look(2'b10, 1'b1, 1'b0, 1'b1, 1'b1, "R11 guard ignored");
        // R12: enable with zeroed registers -> nothing granted
        do_write(2'd0, 64'h1);
        sweep(1'b0, "R12 zero perm EL0");
        sweep(1'b1, "R12 zero perm EL1");
        // R4/R5 overrides in EL1, R6 with distinct EL0 contents
        do_write(2'd2, 64'h0000_0090_0070_0000); // idx5=0111, idx9=1001
        do_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        look(2'b01, 1'b0, 1'b1, 1'b1, 1'b0, "R4 override none");
        look(2'b01, 1'b0, 1'b1, 1'b1, 1'b1, "R4 guarded rx");
        look(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, "R5 override x-only");
        look(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, "R5 guarded ro");
        look(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, "R6 EL0 register");
        // R1: distinct entries per index
        do_write(2'd1, 64'hFEDC_BA98_7654_3210);
        sweep(1'b0, "R1 index order");
        // R7: sel 3 ignored
        do_write(2'd3, 64'h0);
        sweep(1'b0, "R7 sel3 ignored");
        random_phase(1500, 1'b0);
        // R8/R10: lock EL0 perm, keep enable
        do_write(2'd0, 64'h11);
        do_write(2'd1, 64'h0123_4567_89AB_CDEF);
        sweep(1'b0, "R10 EL0 locked");
        do_write(2'd0, 64'h01); // lock not clearable
        do_write(2'd1, 64'h0);
        sweep(1'b0, "R8 lock sticky");
        // R9: freeze config with EL1 lock
        do_write(2'd0, 64'h23);
        do_write(2'd0, 64'h0);
        look(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, "R9 cfg frozen");
        do_write(2'd2, 64'h5555_5555_5555_5555);
        sweep(1'b1, "R10 EL1 locked");
        // R12: second reset clears locks
        do_reset();
        do_write(2'd0, 64'h1);
        do_write(2'd1, 64'hAAAA_AAAA_AAAA_AAAA);
        sweep(1'b0, "R12 locks cleared");
        random_phase(1500, 1'b1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule